// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Registers

This block holds two independent down-counting timers. Each timer has a reload value, a live count that can be read back, and a control word. The control word chooses an operation (load, hold or run) and one of four clock-rate sources. Each source arrives as a one-cycle tick-enable input, so every register sits in the single system clock domain.

A running timer counts down once per tick of its chosen source. When it passes zero it reloads and latches an expiry flag in a shared raw-status register. A mask register gates that status into a masked view and into a single level-sensitive interrupt line. Software clears flags by writing ones to a clear-only address, which stores nothing.

The register port is single-cycle. Writes take effect at the clock edge. Read data is combinational and is valid in the same cycle as `rd_en`.

Top module: `dual_timer_regs`

## Requirements
- R1: After synchronous active-low reset, every reload, control, count, raw-status and mask register reads zero and `irq` is low.
- R2: Byte offsets are: timer0 reload 0x00, count 0x04, control 0x08; timer1 reload 0x10, count 0x14, control 0x18; mask 0x48; clear 0x4C; raw status 0x50; masked status 0x54. Control bits [1:0] hold the operation and bits [4:2] hold the source code. Writing a control word whose operation is 0 copies the timer's reload value into its count at that edge. A count read returns the live count.
- R3: With operation 2 (run) and source code 4, 5, 6 or 7, the count drops by one on each cycle where `tick_src[code-4]` is high. Ticks on the other sources are ignored.
- R4: With operation 1 or 3, the count does not change whatever the ticks.
- R5: Source codes 0 to 3 select no tick, so a timer set to run with such a code does not advance.
- R6: A selected tick while the count is zero reloads the count from the reload register and sets raw-status bit 0 (timer0) or bit 1 (timer1).
- R7: A write to the clear address clears each raw-status bit whose data bit is one. The other bits are left alone, and the address reads zero. An expiry in the same cycle as its clear leaves the bit set.
- R8: The masked status equals raw status AND mask. `irq` is high exactly when the masked status is non-zero.
- R9: Reads of unmapped offsets return zero, and `rdata` is zero whenever `rd_en` is low.
- R10: The two timers are independent. Ticks and control writes for one timer never change the other timer's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid in the cycle `rd_en` is high |
| tick_src | input | N_SRC | Tick enables of the selectable clock-rate sources |
| irq | output | 1 | Level interrupt, high when any masked flag is set |

## Verification
On every cycle the assertions check the following:
- a held count stays frozen;
- a count only ever steps down by one, apart from load and reload;
- a raw flag rises only after an expiry;
- a clear without a competing expiry drops its flag;
- the masked-status read agrees with `irq`;
- idle reads return zero.

Some behaviours can only be shown by the bench's scenarios. These are the exact count after a given number of ticks on the selected source, the rejection of ticks on the other sources, the reload value after expiry, and the set-beats-clear collision. So are the readback of the mask and the two timers running side by side with different sources.

// File: rtl/dtmr_pkg.sv
// Shared constants for the dual timer block: register offsets, field
// positions and operation codes. Assumes byte addressing of 32-bit words.
package dtmr_pkg;
    localparam int TMR_STRIDE  = 'h10;
    localparam int OFS_RELOAD  = 'h00;
    localparam int OFS_COUNT   = 'h04;
    localparam int OFS_CTRL    = 'h08;
    localparam int REG_MASK    = 'h48;
    localparam int REG_CLEAR   = 'h4C;
    localparam int REG_RAW     = 'h50;
    localparam int REG_MASKED  = 'h54;

    localparam int OP_W        = 2;
    localparam int SEL_W       = 3;
    localparam int CTRL_W      = OP_W + SEL_W;
    localparam int SEL_FIRST   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 2'd0,
        OP_HOLD  = 2'd1,
        OP_RUN   = 2'd2,
        OP_SPARE = 2'd3
    } tmr_op_e;
endpackage

// File: rtl/dtmr_counter.sv
// One down-counter with source selection and reload on expiry.
// Assumes the load and advance controls come from the register decoder.
// The load takes priority over advancing.
module dtmr_counter
    import dtmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic [N_SRC-1:0] tick_src,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic sel_tick;
    logic adv;

    // Pick the tick of the selected source; unlisted codes give none.
    always_comb begin
        sel_tick = 1'b0;
        for (int k = 0; k < N_SRC; k++) begin
            if (int'(sel) == SEL_FIRST + k) sel_tick = tick_src[k];
        end
    end

    assign adv    = run && sel_tick;
    assign expire = adv && (count == '0);

    // Count register: load, reload on expiry, or step down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= reload;
        end else if (adv) begin
            count <= (count == '0) ? reload : count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/dtmr_irq.sv
// Raw flags, mask and level interrupt shared by the timers.
// Assumes clear and mask strobes last one cycle. A set wins over a
// clear in the same cycle.
module dtmr_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] expire,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_val,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_val,
    output logic [N-1:0] raw,
    output logic [N-1:0] mask,
    output logic         irq
);
    // Raw flag register: clear selected bits, then merge new expiries.
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~(clr_wr ? clr_val : '0)) | expire;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= mask_val;
    end

    assign irq = |(raw & mask);
endmodule

// File: rtl/dual_timer_regs.sv
// Top of the dual timer: register decode, per-timer reload and control
// storage, two counters and the shared interrupt logic. Assumes
// CNT_W <= 32 and word-aligned byte offsets on addr.
module dual_timer_regs
    import dtmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int N_SRC  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    input  logic [N_SRC-1:0]  tick_src,
    output logic              irq
);
    localparam int NT = 2;

    logic [NT-1:0][CNT_W-1:0]  reload_q;
    logic [NT-1:0][CNT_W-1:0]  cnt;
    logic [NT-1:0][CTRL_W-1:0] ctrl_q;
    logic [NT-1:0]             expire;
    logic [NT-1:0]             ld;
    logic [NT-1:0]             run;
    logic [NT-1:0]             raw;
    logic [NT-1:0]             mask;
    logic                      clr_wr;
    logic                      mask_wr;

    assign clr_wr  = wr_en && (addr == ADDR_W'(REG_CLEAR));
    assign mask_wr = wr_en && (addr == ADDR_W'(REG_MASK));

    for (genvar gi = 0; gi < NT; gi++) begin : g_tmr
        localparam int BASE = gi * TMR_STRIDE;
        logic rl_wr;
        logic ct_wr;

        assign rl_wr = wr_en && (addr == ADDR_W'(BASE + OFS_RELOAD));
        assign ct_wr = wr_en && (addr == ADDR_W'(BASE + OFS_CTRL));

        // Reload and control storage for this timer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reload_q[gi] <= '0;
                ctrl_q[gi]   <= '0;
            end else begin
                if (rl_wr) reload_q[gi] <= wdata[CNT_W-1:0];
                if (ct_wr) ctrl_q[gi]   <= wdata[CTRL_W-1:0];
            end
        end

        assign ld[gi]  = ct_wr && (wdata[OP_W-1:0] == OP_LOAD);
        assign run[gi] = (ctrl_q[gi][OP_W-1:0] == OP_RUN);

        dtmr_counter #(.CNT_W(CNT_W), .N_SRC(N_SRC)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld[gi]),
            .run      (run[gi]),
            .sel      (ctrl_q[gi][CTRL_W-1:OP_W]),
            .tick_src (tick_src),
            .reload   (reload_q[gi]),
            .count    (cnt[gi]),
            .expire   (expire[gi])
        );
    end

    dtmr_irq #(.N(NT)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .clr_wr   (clr_wr),
        .clr_val  (wdata[NT-1:0]),
        .mask_wr  (mask_wr),
        .mask_val (wdata[NT-1:0]),
        .raw      (raw),
        .mask     (mask),
        .irq      (irq)
    );

    // Read multiplexer; anything unmapped or idle returns zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < NT; i++) begin
                if (addr == ADDR_W'(i * TMR_STRIDE + OFS_RELOAD)) rdata = 32'(reload_q[i]);
                if (addr == ADDR_W'(i * TMR_STRIDE + OFS_COUNT))  rdata = 32'(cnt[i]);
                if (addr == ADDR_W'(i * TMR_STRIDE + OFS_CTRL))   rdata = 32'(ctrl_q[i]);
            end
            if (addr == ADDR_W'(REG_MASK))   rdata = 32'(mask);
            if (addr == ADDR_W'(REG_RAW))    rdata = 32'(raw);
            if (addr == ADDR_W'(REG_MASKED)) rdata = 32'(raw & mask);
        end
    end
endmodule

// File: rtl/dtmr_chk.sv
// Property checker for dual_timer_regs, attached through bind.
// Observes ports plus the counter, flag and control nets of the top.
module dtmr_chk
    import dtmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic                 wr_en,
    input logic [31:0]          wdata,
    input logic                 rd_en,
    input logic [31:0]          rdata,
    input logic                 irq,
    input logic [1:0][CNT_W-1:0] cnt,
    input logic [1:0][CNT_W-1:0] reload_q,
    input logic [1:0]           raw,
    input logic [1:0]           run,
    input logic [1:0]           ld,
    input logic [1:0]           expire
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (raw == '0 && !irq));

    // R9
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

    // R8
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(REG_MASKED)) |-> ((rdata != '0) == irq));

    for (genvar i = 0; i < 2; i++) begin : g_t
        // R4
        hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && !ld[i]) |=> $stable(cnt[i]));

        // R3
        step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ld[i] && cnt[i] != '0) |=>
                (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) - CNT_W'(1)));

        // R6
        reload_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[i] && !ld[i]) |=> cnt[i] == $past(reload_q[i]));

        // R6
        flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw[i]) |-> $past(expire[i]));

        // R7
        clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(REG_CLEAR) && wdata[i] && !expire[i]) |=> !raw[i]);
    end
endmodule

bind dual_timer_regs dtmr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .irq      (irq),
    .cnt      (cnt),
    .reload_q (reload_q),
    .raw      (raw),
    .run      (run),
    .ld       (ld),
    .expire   (expire)
);

// File: tb/dual_timer_regs_test.sv
// Scoreboard bench: driver tasks queue expected results, a monitor at the
// falling edge pops and compares them against rdata or irq.
module dual_timer_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  tick_src = '0;
    logic        irq;
    logic        probe_irq = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    dual_timer_regs uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .tick_src(tick_src), .irq(irq)
    );

    // Monitor: compare each probed cycle against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && (rd_en || probe_irq)) begin
            item_t it;
            logic [31:0] act;
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: actual empty queue expected an item");
            end else begin
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : rdata;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [7:0] a, input logic [31:0] d, input logic [3:0] m);
        addr = a; wdata = d; wr_en = 1'b1; tick_src = m;
        step();
        wr_en = 1'b0; tick_src = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_q.push_back('{is_irq: 1'b0, exp: e, tag: tag});
        addr = a; rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        sb_q.push_back('{is_irq: 1'b1, exp: {31'b0, e}, tag: tag});
        probe_irq = 1'b1;
        step();
        probe_irq = 1'b0;
    endtask

    task automatic tick(input logic [3:0] m);
        tick_src = m;
        step();
        tick_src = '0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        rd(8'h04, 32'h0, "R1 timer0 count after reset");
        rd(8'h50, 32'h0, "R1 raw after reset");
        rd(8'h48, 32'h0, "R1 mask after reset");
        chk_irq(1'b0, "R1 irq after reset");

        rd(8'h3C, 32'h0, "R9 unmapped 0x3C");
        rd(8'h20, 32'h0, "R9 unmapped 0x20");

        // R2: load reload=3 into timer0, source code 4.
        wr(8'h00, 32'd3);
        wr(8'h08, 32'h10);
        rd(8'h04, 32'd3, "R2 loaded count");
        rd(8'h08, 32'h10, "R2 control readback");

        // R3: run on source 0 only.
        wr(8'h08, 32'h12);
        tick(4'b0010);
        rd(8'h04, 32'd3, "R3 other source ignored");
        tick(4'b0001);
        rd(8'h04, 32'd2, "R3 one tick");
        tick(4'b0001);
        tick(4'b0001);
        rd(8'h04, 32'd0, "R3 reached zero");
        rd(8'h50, 32'h0, "R6 no flag at zero");

        // R6: tick at zero reloads and flags bit 0.
        tick(4'b0001);
        rd(8'h04, 32'd3, "R6 reload after expiry");
        rd(8'h50, 32'h1, "R6 raw bit0 set");
        chk_irq(1'b0, "R8 irq masked off");

        // R8: unmask.
        wr(8'h48, 32'h3);
        chk_irq(1'b1, "R8 irq after unmask");
        rd(8'h54, 32'h1, "R8 masked status");

        // R4: hold with op 1 and op 3.
        wr(8'h08, 32'h11);
        tick(4'b1111);
        rd(8'h04, 32'd3, "R4 op1 holds");
        wr(8'h08, 32'h13);
        tick(4'b1111);
        rd(8'h04, 32'd3, "R4 op3 holds");

        // R5: run with source code 1 does not advance.
        wr(8'h08, 32'h06);
        tick(4'b1111);
        rd(8'h04, 32'd3, "R5 disabled source");

        // R7: clear only set bits, clear address reads zero.
        wr(8'h4C, 32'h2);
        rd(8'h50, 32'h1, "R7 clear of unset bit");
        wr(8'h4C, 32'h1);
        rd(8'h50, 32'h0, "R7 bit0 cleared");
        chk_irq(1'b0, "R8 irq after clear");
        rd(8'h4C, 32'h0, "R7 clear address reads zero");

        // R10: timer1 on source code 7 (tick_src[3]), reload 1.
        wr(8'h10, 32'd1);
        wr(8'h18, 32'h1C);
        wr(8'h18, 32'h1E);
        rd(8'h18, 32'h1E, "R2 timer1 control readback");
        tick(4'b1000);
        rd(8'h14, 32'd0, "R10 timer1 stepped");
        rd(8'h04, 32'd3, "R10 timer0 untouched");
        tick(4'b1000);
        rd(8'h14, 32'd1, "R6 timer1 reload");
        rd(8'h50, 32'h2, "R6 raw bit1 set");
        chk_irq(1'b1, "R8 irq from timer1");
        rd(8'h54, 32'h2, "R8 masked bit1");
        wr(8'h48, 32'h1);
        chk_irq(1'b0, "R8 irq masked timer1");
        rd(8'h54, 32'h0, "R8 masked zero");
        rd(8'h48, 32'h1, "R8 mask readback");

        // R7: expiry and clear in the same cycle keep the flag.
        tick(4'b1000);
        rd(8'h14, 32'd0, "R3 timer1 at zero");
        wr_tick(8'h4C, 32'h2, 4'b1000);
        rd(8'h50, 32'h2, "R7 set wins over clear");
        rd(8'h14, 32'd1, "R6 timer1 reload again");

        step();
        summary();
    end
endmodule